// File: doc/BRIEF.md
# Ternary Codeword Unpacker (81 bits to 64 bits)

This block turns an 81-bit codeword, read from an array of three-level storage cells, back into the 64-bit data word that was packed into it. The codeword holds eight 10-bit groups. Each group is five 2-bit symbols, and each symbol is one of three legal levels. A group therefore carries one of 243 values. Most byte values fit directly in one group. The 13 byte values that contain three or four `11` bit pairs cannot, so they are packed in a second way. A group of that second kind also carries the byte's original slot and the kind of the group that follows it.

A flag bit says whether any group of the second kind is present. If the flag is set, the groups of the second kind sit together at the front of the codeword, and their chain of next-kind fields marks where they end. The unpacker decodes every group both ways in parallel and finds that boundary. It writes each second-kind byte to the slot that byte names, then fills the remaining slots in ascending order with the ordinary bytes. It accepts one codeword per clock and returns the word, with a valid strobe and an error flag, a fixed number of cycles later.

Top module: `tern_unpack81`

## Requirements
- R1: Group g occupies codeword bits [10g+9:10g] and bit 80 is the flag. Symbol i of a group occupies bits [2i+1:2i] of the group. The group value is the sum over i of symbol_i times 3^i.
- R2: A plain group with value v (0..242) decodes to the v-th byte, counted from 0 in ascending order, among the 243 bytes that have fewer than three `11` bit pairs.
- R3: An escaped group has value v = 104*nxt + 13*pos + pat, with nxt in 0..1, pos in 0..7 and pat in 0..12. It decodes to the pat-th byte, in ascending order, among the 13 bytes that have three or more `11` bit pairs.
- R4: With the flag clear, every group is plain and group g goes to output byte g, which occupies bits [8g+7:8g].
- R5: With the flag set, the escaped cluster starts at group 0 and ends at the first group whose nxt is 0. If no group in the cluster has nxt equal to 0, all eight groups are escaped.
- R6: Each escaped byte is written to the output byte slot given by its pos field.
- R7: The plain groups that follow the cluster fill the slots that no escaped byte claims. They fill those slots in ascending slot order and keep their group order.
- R8: out_err is 1 if any group in the codeword holds the symbol `11`, if an escaped group has a value of 208 or more, or if two escaped groups name the same slot. Otherwise out_err is 0.
- R9: A codeword sampled with in_vld on a clock edge produces out_vld, out_data and out_err after the second following edge, which is three register stages. A new codeword is accepted on every cycle.
- R10: While rst is high and on the cycle after it, out_vld and out_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Codeword strobe |
| in_cw | input | 81 | Codeword: flag in bit 80, eight groups below it |
| out_vld | output | 1 | Result strobe |
| out_data | output | 64 | Rebuilt data word |
| out_err | output | 1 | Codeword is malformed |

## Verification
A wrong boundary or a wrong claim mask shows up in the same output word. In that word, one or more bytes either land in the wrong slot or are taken from the wrong decoder. The bench catches this three cycles after the codeword goes in, by comparing against the original word. A fault in either lookup corrupts single bytes in every word that uses the affected value. Mixed class counts and a reversed cluster order make sure the scatter and fill paths are each exercised. Missed error conditions show up as a clear error flag on codewords that were built to be malformed.

// File: rtl/tern_pkg.sv
package tern_pkg;

    localparam int GRPS    = 8;
    localparam int SYMS    = 5;
    localparam int GW      = 2 * SYMS;
    localparam int BW      = 8;
    localparam int CW      = GRPS * GW + 1;
    localparam int DW      = GRPS * BW;
    localparam int PW      = $clog2(GRPS);
    localparam int NESC    = 13;
    localparam int ESC_LIM = 2 * GRPS * NESC;
    localparam int NXT_W   = GRPS * NESC;
    localparam int VW      = 9;

    typedef struct packed {
        logic [BW-1:0] plain_b;
        logic [BW-1:0] esc_b;
        logic [PW-1:0] pos;
        logic          nxt;
        logic          sym_bad;
        logic          esc_bad;
    } grp_dec_t;

    // ascending list of bytes holding three or more 11 pairs
    function automatic logic [BW-1:0] esc_byte(input logic [3:0] k);
        case (k)
            4'd0:    return 8'h3F;
            4'd1:    return 8'h7F;
            4'd2:    return 8'hBF;
            4'd3:    return 8'hCF;
            4'd4:    return 8'hDF;
            4'd5:    return 8'hEF;
            4'd6:    return 8'hF3;
            4'd7:    return 8'hF7;
            4'd8:    return 8'hFB;
            4'd9:    return 8'hFC;
            4'd10:   return 8'hFD;
            4'd11:   return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic is_esc(input logic [BW-1:0] b);
        int n;
        n = 0;
        for (int i = 0; i < BW / 2; i++)
            if (b[2*i +: 2] == 2'b11) n++;
        return n >= 3;
    endfunction

    function automatic logic has_hi_sym(input logic [GW-1:0] g);
        logic r;
        r = 1'b0;
        for (int i = 0; i < SYMS; i++)
            if (g[2*i +: 2] == 2'b11) r = 1'b1;
        return r;
    endfunction

    function automatic logic [VW-1:0] tern_val(input logic [GW-1:0] g);
        logic [VW-1:0] acc;
        logic [VW-1:0] w;
        acc = '0;
        w   = 9'd1;
        for (int i = 0; i < SYMS; i++) begin
            acc = acc + VW'({7'd0, g[2*i +: 2]} * w);
            w   = VW'(w * 9'd3);
        end
        return acc;
    endfunction

    // v-th plain byte: step over every escaped value not above it
    function automatic logic [BW-1:0] plain_byte(input logic [VW-1:0] v);
        logic [VW-1:0] b;
        b = v;
        for (int k = 0; k < NESC; k++)
            if (b >= {1'b0, esc_byte(4'(k))}) b = b + 9'd1;
        return BW'(b);
    endfunction

endpackage

// File: rtl/tern_grp_dec.sv
module tern_grp_dec
    import tern_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] grp,
    output grp_dec_t      dec
);

    logic [VW-1:0] val;
    logic [VW-1:0] rem;

    always_comb begin
        val         = tern_val(grp);
        dec.sym_bad = has_hi_sym(grp);
        dec.plain_b = plain_byte(val);
        dec.esc_bad = (val >= VW'(ESC_LIM));
        dec.nxt     = (val >= VW'(NXT_W));
        rem         = dec.nxt ? val - VW'(NXT_W) : val;
        dec.pos     = PW'(rem / VW'(NESC));
        dec.esc_b   = esc_byte(4'(rem % VW'(NESC)));
    end

    // R2: a legal plain group never yields an escaped byte value
    a_r2_plain_range: assert property (@(posedge clk) disable iff (rst)
        !dec.sym_bad |-> !is_esc(dec.plain_b));

    // R3: an in-range escaped group always yields an escaped byte value
    a_r3_esc_range: assert property (@(posedge clk) disable iff (rst)
        (!dec.sym_bad && !dec.esc_bad) |-> is_esc(dec.esc_b));

endmodule

// File: rtl/tern_order.sv
module tern_order
    import tern_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          flag,
    input  grp_dec_t      dec [GRPS],
    output logic [DW-1:0] data,
    output logic          err
);

    localparam int CNTW = PW + 1;

    logic [CNTW-1:0] bnd;
    logic [GRPS-1:0] claim;
    logic [GRPS-1:0] fill;
    logic            dup;
    logic            esc_err;
    logic            sym_err;

    // boundary: first escaped group whose next-kind field is plain
    always_comb begin
        logic found;
        found = 1'b0;
        bnd   = '0;
        if (flag) begin
            bnd = CNTW'(GRPS);
            for (int g = 0; g < GRPS; g++)
                if (!found && !dec[g].nxt) begin
                    bnd   = CNTW'(g + 1);
                    found = 1'b1;
                end
        end
    end

    // scatter escaped bytes, then fill the free slots in order
    always_comb begin
        logic [CNTW-1:0] k;
        data    = '0;
        claim   = '0;
        fill    = '0;
        dup     = 1'b0;
        esc_err = 1'b0;
        sym_err = 1'b0;
        for (int g = 0; g < GRPS; g++) begin
            sym_err = sym_err | dec[g].sym_bad;
            if (CNTW'(g) < bnd) begin
                if (claim[dec[g].pos]) dup = 1'b1;
                claim[dec[g].pos]            = 1'b1;
                data[dec[g].pos*BW +: BW]    = dec[g].esc_b;
                esc_err                      = esc_err | dec[g].esc_bad;
            end
        end
        k = bnd;
        for (int s = 0; s < GRPS; s++) begin
            if (!claim[s]) begin
                if (k < CNTW'(GRPS)) begin
                    data[s*BW +: BW] = dec[PW'(k)].plain_b;
                    fill[s]          = 1'b1;
                end
                k = k + 1'b1;
            end
        end
        err = sym_err | esc_err | dup;
    end

    // R6: without a duplicate, the slots claimed match the cluster length
    a_r6_claims: assert property (@(posedge clk) disable iff (rst)
        !dup |-> ($countones(claim) == int'(bnd)));

    // R7: every slot of an error-free word is written exactly once
    a_r7_cover: assert property (@(posedge clk) disable iff (rst)
        !err |-> (((claim | fill) == '1) && ((claim & fill) == '0)));

    // R4: with the flag clear no escaped byte claims a slot
    a_r4_plain_only: assert property (@(posedge clk) disable iff (rst)
        !flag |-> (claim == '0));

endmodule

// File: rtl/tern_unpack81.sv
module tern_unpack81
    import tern_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [CW-1:0] in_cw,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic          out_err
);

    logic            v1;
    logic [CW-1:0]   cw1;
    logic            v2;
    logic            flag2;
    grp_dec_t        dec_c [GRPS];
    grp_dec_t        dec2  [GRPS];
    logic [DW-1:0]   data_c;
    logic            err_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1  <= 1'b0;
            cw1 <= '0;
        end else begin
            v1  <= in_vld;
            cw1 <= in_cw;
        end
    end

    for (genvar g = 0; g < GRPS; g++) begin : g_grp
        tern_grp_dec u_dec (
            .clk (clk),
            .rst (rst),
            .grp (cw1[g*GW +: GW]),
            .dec (dec_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v2    <= 1'b0;
            flag2 <= 1'b0;
            for (int g = 0; g < GRPS; g++) dec2[g] <= '0;
        end else begin
            v2    <= v1;
            flag2 <= cw1[CW-1];
            for (int g = 0; g < GRPS; g++) dec2[g] <= dec_c[g];
        end
    end

    tern_order u_ord (
        .clk  (clk),
        .rst  (rst),
        .flag (flag2),
        .dec  (dec2),
        .data (data_c),
        .err  (err_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
            out_err  <= 1'b0;
        end else begin
            out_vld  <= v2;
            out_data <= data_c;
            out_err  <= err_c;
        end
    end

    // R9: a result strobe always traces back to a codeword three edges earlier
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld, 3));

    // R10: the cycle after reset shows no result and no error
    a_r10_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_vld && !out_err));

endmodule

// File: tb/sim_tern_unpack81.sv
module sim_tern_unpack81;

    localparam int CLK_NS = 10;
    localparam int MAXV   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [80:0] in_cw = '0;
    logic        out_vld;
    logic [63:0] out_data;
    logic        out_err;

    int total = 0;
    int bad   = 0;

    logic [80:0] q_cw  [MAXV];
    logic [63:0] q_dat [MAXV];
    bit          q_err [MAXV];
    bit          q_vld [MAXV];
    int          nv = 0;

    always #(CLK_NS/2) clk = ~clk;

    tern_unpack81 u0 (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_cw    (in_cw),
        .out_vld  (out_vld),
        .out_data (out_data),
        .out_err  (out_err)
    );

    function automatic int pairs11(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 4; i++) if (b[2*i +: 2] == 2'b11) n++;
        return n;
    endfunction

    function automatic bit esc(input logic [7:0] b);
        return pairs11(b) >= 3;
    endfunction

    function automatic int rank(input logic [7:0] b);
        int n = 0;
        for (int x = 0; x < 256; x++)
            if (x < int'(b) && esc(8'(x)) == esc(b)) n++;
        return n;
    endfunction

    function automatic logic [7:0] nth_esc(input int k);
        int n = 0;
        logic [7:0] r = '0;
        for (int x = 0; x < 256; x++)
            if (esc(8'(x))) begin
                if (n == k) r = 8'(x);
                n++;
            end
        return r;
    endfunction

    function automatic logic [9:0] tern(input int v);
        logic [9:0] r;
        int t = v;
        for (int i = 0; i < 5; i++) begin
            r[2*i +: 2] = 2'(t % 3);
            t = t / 3;
        end
        return r;
    endfunction

    // pack per R1-style layout; rev lists escaped bytes from the top slot,
    // last1 leaves nxt=1 on the final escaped group
    function automatic logic [80:0] pack(input logic [63:0] w, input bit rev, input bit last1);
        logic [80:0] cw = '0;
        int ne = 0;
        int g = 0;
        int seen = 0;
        for (int s = 0; s < 8; s++) if (esc(w[8*s +: 8])) ne++;
        for (int i = 0; i < 8; i++) begin
            int s = rev ? 7 - i : i;
            if (esc(w[8*s +: 8])) begin
                int nx;
                seen++;
                nx = (seen < ne || last1) ? 1 : 0;
                cw[10*g +: 10] = tern(104*nx + 13*s + rank(w[8*s +: 8]));
                g++;
            end
        end
        for (int s = 0; s < 8; s++)
            if (!esc(w[8*s +: 8])) begin
                cw[10*g +: 10] = tern(rank(w[8*s +: 8]));
                g++;
            end
        cw[80] = (ne > 0);
        return cw;
    endfunction

    function automatic logic [63:0] rand_word(input int pct);
        logic [63:0] w;
        for (int s = 0; s < 8; s++) begin
            if (int'($urandom % 100) < pct) w[8*s +: 8] = nth_esc(int'($urandom % 13));
            else begin
                logic [7:0] b;
                b = 8'($urandom);
                while (esc(b)) b = 8'($urandom);
                w[8*s +: 8] = b;
            end
        end
        return w;
    endfunction

    task automatic add(input logic [80:0] cw, input logic [63:0] d, input bit e, input bit v);
        q_cw[nv] = cw; q_dat[nv] = d; q_err[nv] = e; q_vld[nv] = v;
        nv++;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input int i);
        chk(out_vld == q_vld[i], "R9 strobe", 64'(out_vld), 64'(q_vld[i]));
        if (q_vld[i]) begin
            chk(out_err == q_err[i], "R8 error flag", 64'(out_err), 64'(q_err[i]));
            if (!q_err[i])
                chk(out_data == q_dat[i], "R2/R3/R5 R6 R7 data", out_data, q_dat[i]);
        end
    endtask

    initial begin
        #(CLK_NS * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] w;
        logic [80:0] cw;
        void'($urandom(32'd1234));

        // R4: all plain bytes, flag clear, identity order
        add(pack(64'h0, 0, 0), 64'h0, 0, 1);
        add(pack(64'h0123_4567_89AB_CDEE, 0, 0), 64'h0123_4567_89AB_CDEE, 0, 1);
        // R5: all escaped, cluster spans all eight groups
        add(pack(64'hFFFF_FFFF_FFFF_FFFF, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
        // R5: no nxt=0 anywhere, boundary still 8
        w = 64'h3F7F_BFCF_DFEF_F3FC;
        add(pack(w, 0, 1), w, 0, 1);
        // R6: single escaped byte in the top slot, then in slot 0
        w = 64'hFE00_1122_3344_5566;
        add(pack(w, 0, 0), w, 0, 1);
        w = 64'h0011_2233_4455_66F7;
        add(pack(w, 0, 0), w, 0, 1);
        // R6 R7: cluster stored in reversed slot order
        w = 64'h1234_FF56_78CF_9A00;
        add(pack(w, 1, 0), w, 0, 1);
        // R9: a bubble cycle in the stream
        add('0, '0, 0, 0);
        // R8: an 11 symbol in a plain codeword
        cw = pack(64'h0102_0304_0506_0708, 0, 0);
        cw[10*3 +: 2] = 2'b11;
        add(cw, '0, 1, 1);
        // R8: escaped group value 210
        cw = pack(64'hFF00_0000_0000_0000, 0, 0);
        cw[9:0] = tern(210);
        add(cw, '0, 1, 1);
        // R8: two escaped groups naming slot 4
        cw = '0;
        cw[80] = 1'b1;
        cw[9:0]   = tern(104 + 13*4 + 0);
        cw[19:10] = tern(13*4 + 1);
        add(cw, '0, 1, 1);
        // R8: an 11 symbol beyond the cluster
        cw = pack(64'h00FF_0000_0000_0000, 0, 0);
        cw[10*6 + 4 +: 2] = 2'b11;
        add(cw, '0, 1, 1);
        // random words with mixed escape density
        for (int i = 0; i < 40; i++) begin
            w = rand_word((i % 4) * 30);
            add(pack(w, i % 2 == 1, 0), w, 0, 1);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: outputs clear right after reset
        chk(out_vld == 1'b0, "R10 reset vld", 64'(out_vld), 64'd0);
        chk(out_err == 1'b0, "R10 reset err", 64'(out_err), 64'd0);

        for (int t = 0; t < nv + 3; t++) begin
            if (t >= 3) check_out(t - 3);
            if (t < nv) begin
                in_vld = q_vld[t];
                in_cw  = q_cw[t];
            end else begin
                in_vld = 1'b0;
                in_cw  = '0;
            end
            @(negedge clk);
        end
        chk(out_vld == 1'b0, "R9 drained", 64'(out_vld), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule